// File: doc/BRIEF.md
# Branch Target Prediction Table

This block sits in the second fetch stage of a deep pipeline and predicts where fetch goes next. Each cycle the next-PC logic presents the current fetch PC. The table compares that PC against every stored branch PC at once. On a match it returns the stored target when the entry's two-bit counter leans taken, and the fall-through address otherwise. On a miss it returns the fall-through address. The prediction comes back to the next-PC logic in the same cycle.

The branch outcome is resolved in the first of two execute stages. That stage drives an update port with four items: the branch PC, the actual direction, the actual target, and the direction and target that fetch predicted for that branch. In that same cycle the block compares the prediction with the real result. When they disagree it raises a mispredict, which flushes the fetch-stage instruction registers and supplies the corrected PC. This gives a fixed two-cycle penalty.

A resolved branch already in the table moves its counter one step. A resolved branch not yet in the table is written into the next slot in round-robin order. A new entry starts out predicting not taken.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses: pred_hit=0, pred_taken=0 and pred_npc = fetch_pc + 4.
- R2: A fetch PC that matches no valid entry gives pred_hit=0, pred_taken=0 and pred_npc = fetch_pc + 4 (STEP_BYTES, default 4).
- R3: A fetch PC that matches a valid entry gives pred_hit=1. pred_taken equals bit 1 of the entry's counter. pred_npc is the stored target when pred_taken=1 and fetch_pc + 4 otherwise.
- R4: An update (upd_valid=1) whose upd_pc is in no valid entry allocates a slot. Slots are chosen in round-robin order 0,1,...,15 and then wrap. The new entry stores upd_pc and upd_target and sets its counter to weakly-not-taken (2'b01), so the next lookup of that PC predicts not taken.
- R5: The counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. An update that hits an entry adds one to its counter when upd_taken=1, saturating at 11. It subtracts one when upd_taken=0, saturating at 00.
- R6: A taken update that hits an entry replaces the stored target with upd_target.
- R7: mispredict is combinational in the update cycle. It is 1 when upd_valid=1 and either upd_pred_taken differs from upd_taken, or both are 1 and upd_pred_target differs from upd_target. redirect_pc is upd_target when upd_taken=1 and upd_pc + 4 otherwise.
- R8: With upd_valid=0, the update inputs change no entry and no prediction.
- R9: Lookup is fully associative: any PC may be held in any slot, and at most one slot matches a given PC. Once all slots are used, the 17th allocation overwrites slot 0, and the PC that was held there then misses.
- R10: A table write becomes visible to lookups on the cycle after the update. A lookup of the same PC in the update cycle still sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_pc | input | 32 | PC from next-PC logic to look up |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_taken | output | 1 | Predicted direction |
| pred_npc | output | 32 | Predicted next PC |
| upd_valid | input | 1 | A resolved branch is on the update port |
| upd_pc | input | 32 | Resolved branch PC |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | 32 | Actual target |
| upd_pred_taken | input | 1 | Direction predicted for this branch at fetch |
| upd_pred_target | input | 32 | Target predicted for this branch at fetch |
| mispredict | output | 1 | Prediction wrong; flush fetch registers |
| redirect_pc | output | 32 | Corrected PC on mispredict |

## Verification
A single branch PC is driven through long runs of taken outcomes and then long runs of not-taken outcomes. This walks its counter through all four states and against both saturation limits, and it also shows whether taken updates refresh the stored target. Updates with upd_valid low, and lookups of PCs that were never stored, separate a real hit from the fall-through default. A fill of more than sixteen distinct PCs shows the round-robin victim order and the eviction of the oldest entry. The mispredict output is driven with four prediction/outcome pairs: direction wrong each way, a wrong target with the right direction, and a full match.

// File: rtl/btb_pkg.sv
package btb_pkg;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'b00,
      CTR_WEAK_NT   = 2'b01,
      CTR_WEAK_T    = 2'b10,
      CTR_STRONG_T  = 2'b11
   } ctr_e;

   // One saturating step of the direction counter.
   function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
      ctr_e nxt;
      nxt = cur;
      if (taken) begin
         if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
      end else begin
         if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
      end
      return nxt;
   endfunction

endpackage

// File: rtl/btb_match.sv
module btb_match #(
   parameter int ENTRIES = 16,
   parameter int PC_W    = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]          valid,
   input  logic [ENTRIES-1:0][PC_W-1:0] tags,
   input  logic [PC_W-1:0]             key,
   output logic [ENTRIES-1:0]          hit_vec,
   output logic                        hit,
   output logic [IDX_W-1:0]            hit_idx
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid[g] && (tags[g] == key);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/btb_rr_ptr.sv
module btb_rr_ptr #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (advance) ptr <= ptr + IDX_W'(1);
   end

   // R9: victim pointer moves exactly one slot per allocation
   p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> ptr == $past(ptr) + IDX_W'(1));

   p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ptr));

endmodule

// File: rtl/btb_entry.sv
module btb_entry
   import btb_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc,
   input  logic            upd_hit,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target,
   output logic            valid,
   output logic [PC_W-1:0] tag,
   output logic [PC_W-1:0] target,
   output ctr_e            ctr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         tag    <= '0;
         target <= '0;
         ctr    <= CTR_WEAK_NT;
      end else if (alloc) begin
         valid  <= 1'b1;
         tag    <= upd_pc;
         target <= upd_target;
         ctr    <= CTR_WEAK_NT;
      end else if (upd_hit) begin
         ctr <= ctr_step(ctr, upd_taken);
         if (upd_taken) target <= upd_target;
      end
   end

   p_alloc_wnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |=> valid && ctr == CTR_WEAK_NT && tag == $past(upd_pc));

   p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_hit && !alloc && upd_taken && ctr == CTR_STRONG_T) |=> ctr == CTR_STRONG_T);

   p_sat_bot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_hit && !alloc && !upd_taken && ctr == CTR_STRONG_NT) |=> ctr == CTR_STRONG_NT);

   p_tgt_refresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_hit && upd_taken) |=> target == $past(upd_target));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!alloc && !upd_hit) |=> $stable(ctr) && $stable(target) && $stable(valid));

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
   import btb_pkg::*;
#(
   parameter int ENTRIES    = 16,
   parameter int PC_W       = 32,
   parameter int STEP_BYTES = 4,
   localparam int IDX_W     = $clog2(ENTRIES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_hit,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_npc,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target,
   input  logic            upd_pred_taken,
   input  logic [PC_W-1:0] upd_pred_target,
   output logic            mispredict,
   output logic [PC_W-1:0] redirect_pc
);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("btb_predictor: ENTRIES must be a power of two, at least 2");
   end
   if (PC_W < 8) begin : g_bad_pcw
      $error("btb_predictor: PC_W too small");
   end
   if (STEP_BYTES < 1) begin : g_bad_step
      $error("btb_predictor: STEP_BYTES must be positive");
   end

   localparam logic [PC_W-1:0] STEP = PC_W'(STEP_BYTES);

   logic [ENTRIES-1:0]           ent_valid;
   logic [ENTRIES-1:0][PC_W-1:0] ent_tag;
   logic [ENTRIES-1:0][PC_W-1:0] ent_target;
   ctr_e                         ent_ctr [ENTRIES];

   logic [ENTRIES-1:0] look_vec, upd_vec, alloc_vec;
   logic               look_hit, upd_any;
   logic [IDX_W-1:0]   look_idx, upd_idx, victim;
   logic               alloc_en;

   btb_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_look_match (
      .valid(ent_valid), .tags(ent_tag), .key(fetch_pc),
      .hit_vec(look_vec), .hit(look_hit), .hit_idx(look_idx));

   btb_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_upd_match (
      .valid(ent_valid), .tags(ent_tag), .key(upd_pc),
      .hit_vec(upd_vec), .hit(upd_any), .hit_idx(upd_idx));

   assign alloc_en = upd_valid && !upd_any;

   btb_rr_ptr #(.ENTRIES(ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .advance(alloc_en), .ptr(victim));

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign alloc_vec[g] = alloc_en && (victim == IDX_W'(g));
      btb_entry #(.PC_W(PC_W)) u_entry (
         .clk(clk), .rst_n(rst_n),
         .alloc(alloc_vec[g]),
         .upd_hit(upd_valid && upd_vec[g]),
         .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
         .valid(ent_valid[g]), .tag(ent_tag[g]),
         .target(ent_target[g]), .ctr(ent_ctr[g]));
   end

   // Prediction
   always_comb begin
      pred_hit   = look_hit;
      pred_taken = look_hit && ent_ctr[look_idx][1];
      pred_npc   = pred_taken ? ent_target[look_idx] : fetch_pc + STEP;
   end

   // Resolution compare
   always_comb begin
      mispredict  = upd_valid &&
                    ((upd_pred_taken != upd_taken) ||
                     (upd_taken && upd_pred_target != upd_target));
      redirect_pc = upd_taken ? upd_target : upd_pc + STEP;
   end

   p_onehot_look_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_vec));

   p_onehot_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd_vec));

   p_miss_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> !pred_taken && pred_npc == fetch_pc + STEP);

   p_flush_needs_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |-> upd_valid);

   p_no_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> $stable(ent_valid) && $stable(ent_tag) && $stable(ent_target));

   p_single_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(alloc_vec));

endmodule

// File: tb/btb_predictor_tb.sv
`timescale 1ns/1ps
module btb_predictor_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        pred_hit, pred_taken, mispredict;
   logic [31:0] pred_npc, redirect_pc;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [31:0] upd_target = '0;
   logic        upd_pred_taken = 1'b0;
   logic [31:0] upd_pred_target = '0;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   btb_predictor dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_npc(pred_npc),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
      .upd_target(upd_target), .upd_pred_taken(upd_pred_taken),
      .upd_pred_target(upd_pred_target),
      .mispredict(mispredict), .redirect_pc(redirect_pc));

   typedef struct packed {
      logic        uv;
      logic [31:0] upc;
      logic        utk;
      logic [31:0] utg;
      logic [31:0] look;
      logic        e_hit;
      logic        e_tk;
      logic [31:0] e_npc;
   } vec_t;

   // A = 0x100, B = 0x200, C = 0x400
   localparam vec_t VEC [14] = '{
      '{1'b1, 32'h100, 1'b1, 32'h800, 32'h100, 1'b1, 1'b0, 32'h104}, // R4 alloc WNT
      '{1'b1, 32'h100, 1'b1, 32'h800, 32'h100, 1'b1, 1'b1, 32'h800}, // R5 -> WT
      '{1'b1, 32'h100, 1'b1, 32'h900, 32'h100, 1'b1, 1'b1, 32'h900}, // R6 -> ST new tgt
      '{1'b1, 32'h100, 1'b1, 32'h900, 32'h100, 1'b1, 1'b1, 32'h900}, // R5 sat top
      '{1'b1, 32'h100, 1'b0, 32'h0,   32'h100, 1'b1, 1'b1, 32'h900}, // R5 -> WT
      '{1'b1, 32'h100, 1'b0, 32'h0,   32'h100, 1'b1, 1'b0, 32'h104}, // R5 -> WNT
      '{1'b1, 32'h100, 1'b0, 32'h0,   32'h100, 1'b1, 1'b0, 32'h104}, // R5 -> SNT
      '{1'b1, 32'h100, 1'b0, 32'h0,   32'h100, 1'b1, 1'b0, 32'h104}, // R5 sat bottom
      '{1'b1, 32'h100, 1'b1, 32'h900, 32'h100, 1'b1, 1'b0, 32'h104}, // R5 -> WNT
      '{1'b0, 32'h200, 1'b1, 32'h300, 32'h200, 1'b0, 1'b0, 32'h204}, // R8 no alloc
      '{1'b1, 32'h200, 1'b0, 32'h300, 32'h200, 1'b1, 1'b0, 32'h204}, // R4 slot1
      '{1'b0, 32'h100, 1'b1, 32'h900, 32'h100, 1'b1, 1'b0, 32'h104}, // R8 no step
      '{1'b1, 32'h200, 1'b1, 32'h300, 32'h200, 1'b1, 1'b1, 32'h300}, // R3 taken
      '{1'b0, 32'h0,   1'b0, 32'h0,   32'h400, 1'b0, 1'b0, 32'h404}  // R2 miss
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic lookup(input logic [31:0] pc, input logic eh, input logic et,
                         input logic [31:0] en, input string tag);
      fetch_pc = pc;
      #1;
      check({tag, " hit"},   {31'b0, pred_hit},   {31'b0, eh});
      check({tag, " taken"}, {31'b0, pred_taken}, {31'b0, et});
      check({tag, " npc"},   pred_npc, en);
   endtask

   task automatic upd_cycle(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg;
      upd_pred_taken = tk; upd_pred_target = tg;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic mp_case(input logic tk, input logic [31:0] tg, input logic ptk,
                          input logic [31:0] ptg, input logic em, input logic [31:0] erd,
                          input string tag);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = 32'h3000; upd_taken = tk; upd_target = tg;
      upd_pred_taken = ptk; upd_pred_target = ptg;
      #1;
      check({tag, " mispredict"}, {31'b0, mispredict}, {31'b0, em});
      check({tag, " redirect"},   redirect_pc, erd);
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   initial begin : watchdog
      #(5.0 * 20000);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state, all lookups miss
      lookup(32'h100, 1'b0, 1'b0, 32'h104, "R1 reset A");
      lookup(32'h7FC, 1'b0, 1'b0, 32'h800, "R1 reset other");
      rst_n = 1'b1;
      @(negedge clk);

      foreach (VEC[i]) begin
         @(negedge clk);
         upd_valid = VEC[i].uv; upd_pc = VEC[i].upc;
         upd_taken = VEC[i].utk; upd_target = VEC[i].utg;
         upd_pred_taken = VEC[i].utk; upd_pred_target = VEC[i].utg;
         @(negedge clk);
         upd_valid = 1'b0;
         lookup(VEC[i].look, VEC[i].e_hit, VEC[i].e_tk, VEC[i].e_npc,
                $sformatf("R3/R5 vec%0d", i));
      end

      // R10: same-cycle lookup sees the old entry (A at WNT)
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = 32'h100; upd_taken = 1'b1; upd_target = 32'hA00;
      upd_pred_taken = 1'b0; upd_pred_target = 32'h0;
      lookup(32'h100, 1'b1, 1'b0, 32'h104, "R10 same cycle");
      @(negedge clk);
      upd_valid = 1'b0;
      lookup(32'h100, 1'b1, 1'b1, 32'hA00, "R10 next cycle");

      // R9: fill remaining slots and wrap; slot pointer is at 2
      for (int k = 0; k < 15; k++) upd_cycle(32'h1000 + 32'(k) * 4, 1'b0, 32'h0);
      lookup(32'h100,  1'b0, 1'b0, 32'h104,  "R9 slot0 evicted");
      lookup(32'h200,  1'b1, 1'b1, 32'h300,  "R9 slot1 kept");
      lookup(32'h1000, 1'b1, 1'b0, 32'h1004, "R9 first fill");
      lookup(32'h1038, 1'b1, 1'b0, 32'h103C, "R9 wrap entry");

      // R7: mispredict compare
      mp_case(1'b1, 32'h500, 1'b0, 32'h0,   1'b1, 32'h500,  "R7 pred nt act t");
      mp_case(1'b0, 32'h500, 1'b1, 32'h500, 1'b1, 32'h3004, "R7 pred t act nt");
      mp_case(1'b1, 32'h500, 1'b1, 32'h600, 1'b1, 32'h500,  "R7 wrong target");
      mp_case(1'b1, 32'h500, 1'b1, 32'h500, 1'b0, 32'h500,  "R7 correct");
      mp_case(1'b0, 32'h500, 1'b0, 32'h999, 1'b0, 32'h3004, "R7 nt ignores target");

      // R1: reset mid-run clears entries
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      lookup(32'h200, 1'b0, 1'b0, 32'h204, "R1 after reset");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule